// File: doc/BRIEF.md
# Domain Permission Cache with Ranged Invalidation

This block keeps a small, fully associative set of recently resolved memory-tracking-table permission results. Each slot is keyed by a supervisor-domain identifier together with a 4 KiB page number and carries an opaque permission field. A checker pipeline presents a lookup and receives a registered hit/miss answer with the stored permission one cycle later. When a table walk has produced a fresh result, the walker writes it in through the fill port.

Software changes to the table are made visible by an invalidate command. Two validity flags pick the scope: the whole cache, one domain, one address range across all domains, or one address range within one domain. The range is either a single page or a naturally aligned power-of-two region. The size of that region comes from the lowest clear bit of the page number operand. A build-time option reduces the engine to a plain flush-everything design that ignores every operand.

Top module: `perm_cache`

## Requirements
- R1: After reset every slot is empty, `lk_rsp_valid` and `lk_hit` are low and `lk_perm` is zero.
- R2: A lookup presented in one cycle is answered in the next cycle with `lk_rsp_valid` high. `lk_hit` is high only when a valid slot holds the same domain and page, and in that case `lk_perm` carries the stored permission. On a miss `lk_perm` is zero.
- R3: A fill whose domain and page are already cached overwrites that slot's permission, so later lookups return the newest value and no stale copy survives an invalidation of that key.
- R4: A command acts only when `cmd_op` equals 3. Any other opcode leaves every slot unchanged.
- R5: With page-valid 0 and domain-valid 0, every slot of every domain is emptied.
- R6: With page-valid 0 and domain-valid 1, only slots whose domain equals `cmd_did` are emptied.
- R7: With page-valid 1, domain-valid 0 and size bit 0, every slot whose page equals `cmd_ppn` exactly is emptied, whatever its domain.
- R8: With page-valid 1 and domain-valid 1, only slots matching both the page range and `cmd_did` are emptied.
- R9: With size bit 1, let x be the index of the lowest 0 bit of `cmd_ppn`. The range covers the 1 << (12+x+1) bytes whose page numbers agree with `cmd_ppn` in every bit above x. For example, PPN 0x103 covers pages 0x100 to 0x107.
- R10: With size bit 1 and an all-ones `cmd_ppn`, the range covers the whole address space.
- R11: A lookup in the same cycle as an invalidation that empties its slot returns a miss.
- R12: A fill with no matching slot takes the lowest-numbered empty slot. When no slot is empty it replaces the slot at a round-robin pointer. Every allocation moves the pointer to one past the slot just written.
- R13: With `GLOBAL_ONLY` set, every command with opcode 3 empties all slots, whatever its flags, page and domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_did | input | DID_W | Lookup domain identifier |
| lk_ppn | input | PPN_W | Lookup page number |
| fill_valid | input | 1 | Fill request |
| fill_did | input | DID_W | Fill domain identifier |
| fill_ppn | input | PPN_W | Fill page number |
| fill_perm | input | PERM_W | Fill permission value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode (3 = invalidate) |
| cmd_ppnv | input | 1 | Page operand valid |
| cmd_didv | input | 1 | Domain operand valid |
| cmd_s | input | 1 | 0: single page, 1: NAPOT range |
| cmd_ppn | input | PPN_W | Page operand |
| cmd_did | input | DID_W | Domain operand |
| lk_rsp_valid | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | Lookup hit |
| lk_perm | output | PERM_W | Stored permission on hit, else zero |

## Verification
The invalidation engine is driven with each of the four flag combinations. Each time, slots are placed so that only the intended scope can tell the combinations apart: same page in two domains, same domain on neighbouring pages. NAPOT decoding is tried with an operand whose lowest zero bit lies in the middle, with pages just inside and just outside both ends of the range, and with an all-ones operand. A lookup issued together with a killing invalidation separates a correctly bypassed answer from one read from the old state. Nine fills into eight slots show which slot the replacement pointer evicts.

// File: rtl/perm_cache_pkg.sv
// Shared constants for the permission cache.
package perm_cache_pkg;
    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_INVAL = 3'd3;
endpackage

// File: rtl/pc_range_mask.sv
// Decodes the invalidate range into a mask of page-number bits to ignore.
// Assumes: with size bit 0 the range is one page (nothing ignored); with
// size bit 1 the bits up to and including the lowest zero bit are ignored.
module pc_range_mask #(
    parameter int PPN_W = 20
) (
    input  logic             size_sel,
    input  logic [PPN_W-1:0] ppn,
    output logic [PPN_W-1:0] mask
);
    // ppn ^ (ppn+1) sets every bit from 0 through the lowest zero bit
    always_comb begin
        mask = size_sel ? (ppn ^ (ppn + 1'b1)) : '0;
    end
endmodule

// File: rtl/pc_entry.sv
// One cache slot: key, permission and valid flag, with its own lookup,
// fill-match and invalidation-match comparators.
// Assumes: a write to this slot takes priority over a same-cycle kill.
module pc_entry #(
    parameter int DID_W       = 8,
    parameter int PPN_W       = 20,
    parameter int PERM_W      = 3,
    parameter bit GLOBAL_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DID_W-1:0]  lk_did,
    input  logic [PPN_W-1:0]  lk_ppn,
    input  logic              wr_en,
    input  logic [DID_W-1:0]  wr_did,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              inv_fire,
    input  logic              inv_ppnv,
    input  logic              inv_didv,
    input  logic [PPN_W-1:0]  inv_ppn,
    input  logic [PPN_W-1:0]  inv_mask,
    input  logic [DID_W-1:0]  inv_did,
    output logic              ent_valid,
    output logic              lk_match,
    output logic              wr_match,
    output logic              kill,
    output logic [PERM_W-1:0] ent_perm
);
    logic [DID_W-1:0] ent_did;
    logic [PPN_W-1:0] ent_ppn;
    logic             dom_ok;
    logic             rng_ok;

    // Key comparisons for lookup and fill
    always_comb begin
        lk_match = ent_valid && (ent_did == lk_did) && (ent_ppn == lk_ppn);
        wr_match = ent_valid && (ent_did == wr_did) && (ent_ppn == wr_ppn);
    end

    // Scope test of the pending invalidation against this slot
    always_comb begin
        dom_ok = !inv_didv || (ent_did == inv_did);
        rng_ok = !inv_ppnv || ((ent_ppn & ~inv_mask) == (inv_ppn & ~inv_mask));
        kill   = inv_fire && ent_valid && (GLOBAL_ONLY ? 1'b1 : (dom_ok && rng_ok));
    end

    // Slot state update: fill first, otherwise invalidate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= 1'b0;
            ent_did   <= '0;
            ent_ppn   <= '0;
            ent_perm  <= '0;
        end else if (wr_en) begin
            ent_valid <= 1'b1;
            ent_did   <= wr_did;
            ent_ppn   <= wr_ppn;
            ent_perm  <= wr_perm;
        end else if (kill) begin
            ent_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pc_victim.sv
// Chooses the slot for a new fill: lowest empty slot, else round-robin.
// Assumes: the pointer moves to one past the written slot on allocation.
module pc_victim #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               alloc,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_ptr;

    // Priority search for the lowest empty slot, falling back to the pointer
    always_comb begin
        victim = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim = IDX_W'(i);
        end
    end

    // Round-robin pointer advance on every allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (alloc) begin
            rr_ptr <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
        end
    end
endmodule

// File: rtl/perm_cache.sv
// Fully associative permission cache keyed by domain and 4 KiB page.
// Lookups answer one cycle later; fills update in place or allocate;
// invalidate commands (opcode 3) empty slots by domain and/or page range.
// Assumes: a lookup sees neither a same-cycle fill nor a slot killed in
// the same cycle.
module perm_cache
    import perm_cache_pkg::*;
#(
    parameter int ENTRIES     = 8,
    parameter int DID_W       = 8,
    parameter int PPN_W       = 20,
    parameter int PERM_W      = 3,
    parameter bit GLOBAL_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [DID_W-1:0]  lk_did,
    input  logic [PPN_W-1:0]  lk_ppn,
    input  logic              fill_valid,
    input  logic [DID_W-1:0]  fill_did,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic              cmd_ppnv,
    input  logic              cmd_didv,
    input  logic              cmd_s,
    input  logic [PPN_W-1:0]  cmd_ppn,
    input  logic [DID_W-1:0]  cmd_did,
    output logic              lk_rsp_valid,
    output logic              lk_hit,
    output logic [PERM_W-1:0] lk_perm
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] lk_match_vec;
    logic [ENTRIES-1:0] wr_match_vec;
    logic [ENTRIES-1:0] kill_vec;
    logic [ENTRIES-1:0] wr_en_vec;
    logic [PERM_W-1:0]  perm_arr [ENTRIES];
    logic [PPN_W-1:0]   inv_mask;
    logic [IDX_W-1:0]   victim;
    logic               inv_fire;
    logic               any_wr_match;
    logic               alloc;
    logic               hit_d;
    logic [PERM_W-1:0]  perm_d;

    // Command decode
    always_comb begin
        inv_fire     = cmd_valid && (cmd_op == OP_INVAL);
        any_wr_match = |wr_match_vec;
        alloc        = fill_valid && !any_wr_match;
    end

    pc_range_mask #(.PPN_W(PPN_W)) u_mask (
        .size_sel (cmd_s),
        .ppn      (cmd_ppn),
        .mask     (inv_mask)
    );

    pc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .alloc     (alloc),
        .victim    (victim)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Write select: in-place update on key match, else the victim slot
        always_comb begin
            wr_en_vec[g] = fill_valid &&
                           (any_wr_match ? wr_match_vec[g] : (victim == IDX_W'(g)));
        end

        pc_entry #(
            .DID_W(DID_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .GLOBAL_ONLY(GLOBAL_ONLY)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_did    (lk_did),
            .lk_ppn    (lk_ppn),
            .wr_en     (wr_en_vec[g]),
            .wr_did    (fill_did),
            .wr_ppn    (fill_ppn),
            .wr_perm   (fill_perm),
            .inv_fire  (inv_fire),
            .inv_ppnv  (cmd_ppnv),
            .inv_didv  (cmd_didv),
            .inv_ppn   (cmd_ppn),
            .inv_mask  (inv_mask),
            .inv_did   (cmd_did),
            .ent_valid (valid_vec[g]),
            .lk_match  (lk_match_vec[g]),
            .wr_match  (wr_match_vec[g]),
            .kill      (kill_vec[g]),
            .ent_perm  (perm_arr[g])
        );
    end

    // Hit merge with bypass of slots killed this cycle
    always_comb begin
        hit_d  = 1'b0;
        perm_d = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match_vec[i] && !kill_vec[i]) begin
                hit_d  = 1'b1;
                perm_d = perm_d | perm_arr[i];
            end
        end
    end

    // Registered lookup answer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rsp_valid <= 1'b0;
            lk_hit       <= 1'b0;
            lk_perm      <= '0;
        end else begin
            lk_rsp_valid <= lk_valid;
            lk_hit       <= lk_valid && hit_d;
            lk_perm      <= lk_valid ? perm_d : '0;
        end
    end
endmodule

// File: rtl/perm_cache_checker.sv
// Temporal checks on the permission cache ports, bound into every instance.
module perm_cache_checker #(
    parameter int DID_W  = 8,
    parameter int PPN_W  = 20,
    parameter int PERM_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [DID_W-1:0]  lk_did,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic              fill_valid,
    input logic [DID_W-1:0]  fill_did,
    input logic [PPN_W-1:0]  fill_ppn,
    input logic [PERM_W-1:0] fill_perm,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              cmd_ppnv,
    input logic              cmd_didv,
    input logic              lk_rsp_valid,
    input logic              lk_hit,
    input logic [PERM_W-1:0] lk_perm
);
    // Every lookup is answered in the next cycle
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_rsp_valid);

    // No answer without a request
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_rsp_valid);

    // A miss carries a zero permission; a hit needs an answer
    assert_miss_perm_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_rsp_valid && !lk_hit) |-> (lk_perm == '0));

    assert_hit_has_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_rsp_valid);

    // Global invalidation together with a lookup gives a miss (R5, R11)
    assert_global_kill_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && cmd_valid && cmd_op == 3'd3 && !cmd_ppnv && !cmd_didv) |=> !lk_hit);

    // A fill is visible to a lookup of the same key in the following cycle
    assert_fill_then_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && lk_valid && $past(fill_valid) &&
         $past(fill_did) == lk_did && $past(fill_ppn) == lk_ppn &&
         !(cmd_valid && cmd_op == 3'd3))
        |=> (lk_hit && lk_perm == $past(fill_perm, 2)));
endmodule

bind perm_cache perm_cache_checker #(
    .DID_W(DID_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_did       (lk_did),
    .lk_ppn       (lk_ppn),
    .fill_valid   (fill_valid),
    .fill_did     (fill_did),
    .fill_ppn     (fill_ppn),
    .fill_perm    (fill_perm),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_ppnv     (cmd_ppnv),
    .cmd_didv     (cmd_didv),
    .lk_rsp_valid (lk_rsp_valid),
    .lk_hit       (lk_hit),
    .lk_perm      (lk_perm)
);

// File: tb/perm_cache_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module perm_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [7:0]  lk_did = '0;
    logic [19:0] lk_ppn = '0;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_did = '0;
    logic [19:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        cmd_ppnv = 1'b0;
    logic        cmd_didv = 1'b0;
    logic        cmd_s = 1'b0;
    logic [19:0] cmd_ppn = '0;
    logic [7:0]  cmd_did = '0;
    logic        rsp_valid, hit, g_rsp_valid, g_hit;
    logic [2:0]  perm, g_perm;

    int checks = 0;
    int fails  = 0;
    logic r_hit, r_ghit;
    logic [2:0] r_perm;

    always #5 clk = ~clk;

    perm_cache u_perm_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_did(lk_did), .lk_ppn(lk_ppn),
        .fill_valid(fill_valid), .fill_did(fill_did), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ppnv(cmd_ppnv), .cmd_didv(cmd_didv),
        .cmd_s(cmd_s), .cmd_ppn(cmd_ppn), .cmd_did(cmd_did),
        .lk_rsp_valid(rsp_valid), .lk_hit(hit), .lk_perm(perm)
    );

    perm_cache #(.GLOBAL_ONLY(1'b1)) u_perm_cache_glob (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_did(lk_did), .lk_ppn(lk_ppn),
        .fill_valid(fill_valid), .fill_did(fill_did), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ppnv(cmd_ppnv), .cmd_didv(cmd_didv),
        .cmd_s(cmd_s), .cmd_ppn(cmd_ppn), .cmd_did(cmd_did),
        .lk_rsp_valid(g_rsp_valid), .lk_hit(g_hit), .lk_perm(g_perm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] d, input logic [19:0] p, input logic [2:0] pm);
        @(negedge clk);
        fill_valid = 1'b1; fill_did = d; fill_ppn = p; fill_perm = pm;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic inval(input logic [2:0] op, input logic pv, input logic dv,
                         input logic s, input logic [19:0] p, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ppnv = pv; cmd_didv = dv;
        cmd_s = s; cmd_ppn = p; cmd_did = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic lookup(input logic [7:0] d, input logic [19:0] p);
        @(negedge clk);
        lk_valid = 1'b1; lk_did = d; lk_ppn = p;
        @(posedge clk);
        #1;
        r_hit = hit; r_perm = perm; r_ghit = g_hit;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic flush_all();
        inval(3'd3, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 hit", 32'(hit), 0);
        chk("R1 perm", 32'(perm), 0);
        lookup(8'd1, 20'h10);
        chk("R1 empty after reset", 32'(r_hit), 0);
    endtask

    task automatic t_fill_lookup();
        flush_all();
        fill(8'd1, 20'h10, 3'd5);
        lookup(8'd1, 20'h10);
        chk("R2 hit", 32'(r_hit), 1);
        chk("R2 perm", 32'(r_perm), 5);
        lookup(8'd2, 20'h10);
        chk("R2 other domain miss", 32'(r_hit), 0);
        chk("R2 miss perm zero", 32'(r_perm), 0);
        lookup(8'd1, 20'h11);
        chk("R2 other page miss", 32'(r_hit), 0);
    endtask

    task automatic t_refill();
        flush_all();
        fill(8'd3, 20'h20, 3'd1);
        fill(8'd3, 20'h20, 3'd6);
        lookup(8'd3, 20'h20);
        chk("R3 newest perm", 32'(r_perm), 6);
        inval(3'd3, 1'b1, 1'b1, 1'b0, 20'h20, 8'd3);
        lookup(8'd3, 20'h20);
        chk("R3 no stale copy", 32'(r_hit), 0);
    endtask

    task automatic t_other_op();
        flush_all();
        fill(8'd1, 20'h30, 3'd2);
        inval(3'd4, 1'b0, 1'b0, 1'b0, '0, '0);
        inval(3'd2, 1'b0, 1'b0, 1'b0, '0, '0);
        lookup(8'd1, 20'h30);
        chk("R4 other opcode ignored", 32'(r_hit), 1);
        chk("R4 perm kept", 32'(r_perm), 2);
    endtask

    task automatic t_global();
        flush_all();
        fill(8'd1, 20'h1, 3'd1);
        fill(8'd2, 20'h2, 3'd2);
        fill(8'd9, 20'hABCDE, 3'd3);
        inval(3'd3, 1'b0, 1'b0, 1'b0, 20'h1, 8'd1);
        lookup(8'd1, 20'h1);     chk("R5 slot a", 32'(r_hit), 0);
        lookup(8'd2, 20'h2);     chk("R5 slot b", 32'(r_hit), 0);
        lookup(8'd9, 20'hABCDE); chk("R5 slot c", 32'(r_hit), 0);
    endtask

    task automatic t_domain();
        flush_all();
        fill(8'd1, 20'h10, 3'd1);
        fill(8'd2, 20'h10, 3'd2);
        inval(3'd3, 1'b0, 1'b1, 1'b0, 20'h77, 8'd1);
        lookup(8'd1, 20'h10); chk("R6 domain 1 gone", 32'(r_hit), 0);
        lookup(8'd2, 20'h10); chk("R6 domain 2 kept", 32'(r_hit), 1);
    endtask

    task automatic t_page_all();
        flush_all();
        fill(8'd1, 20'h40, 3'd1);
        fill(8'd2, 20'h40, 3'd2);
        fill(8'd1, 20'h41, 3'd3);
        inval(3'd3, 1'b1, 1'b0, 1'b0, 20'h40, 8'd7);
        lookup(8'd1, 20'h40); chk("R7 d1 page gone", 32'(r_hit), 0);
        lookup(8'd2, 20'h40); chk("R7 d2 page gone", 32'(r_hit), 0);
        lookup(8'd1, 20'h41); chk("R7 next page kept", 32'(r_hit), 1);
    endtask

    task automatic t_page_dom();
        flush_all();
        fill(8'd1, 20'h50, 3'd1);
        fill(8'd2, 20'h50, 3'd2);
        inval(3'd3, 1'b1, 1'b1, 1'b0, 20'h50, 8'd2);
        lookup(8'd1, 20'h50); chk("R8 other domain kept", 32'(r_hit), 1);
        lookup(8'd2, 20'h50); chk("R8 named domain gone", 32'(r_hit), 0);
    endtask

    task automatic t_napot();
        flush_all();
        fill(8'd1, 20'h100, 3'd1);
        fill(8'd1, 20'h107, 3'd2);
        fill(8'd1, 20'h108, 3'd3);
        fill(8'd1, 20'h0FF, 3'd4);
        inval(3'd3, 1'b1, 1'b0, 1'b1, 20'h103, 8'd0);
        lookup(8'd1, 20'h100); chk("R9 low end gone", 32'(r_hit), 0);
        lookup(8'd1, 20'h107); chk("R9 high end gone", 32'(r_hit), 0);
        lookup(8'd1, 20'h108); chk("R9 above kept", 32'(r_hit), 1);
        lookup(8'd1, 20'h0FF); chk("R9 below kept", 32'(r_hit), 1);
    endtask

    task automatic t_all_ones();
        flush_all();
        fill(8'd1, 20'h12345, 3'd1);
        fill(8'd3, 20'h00001, 3'd2);
        inval(3'd3, 1'b1, 1'b0, 1'b1, 20'hFFFFF, 8'd0);
        lookup(8'd1, 20'h12345); chk("R10 whole space a", 32'(r_hit), 0);
        lookup(8'd3, 20'h00001); chk("R10 whole space b", 32'(r_hit), 0);
    endtask

    task automatic t_same_cycle();
        flush_all();
        fill(8'd4, 20'h60, 3'd7);
        fill(8'd4, 20'h61, 3'd6);
        @(negedge clk);
        lk_valid = 1'b1; lk_did = 8'd4; lk_ppn = 20'h60;
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_ppnv = 1'b1; cmd_didv = 1'b0;
        cmd_s = 1'b0; cmd_ppn = 20'h60; cmd_did = '0;
        @(posedge clk); #1;
        chk("R11 killed lookup misses", 32'(hit), 0);
        @(negedge clk);
        lk_ppn = 20'h61; cmd_ppn = 20'h62;
        @(posedge clk); #1;
        chk("R11 untouched lookup hits", 32'(hit), 1);
        @(negedge clk);
        lk_valid = 1'b0; cmd_valid = 1'b0;
        lookup(8'd4, 20'h60);
        chk("R11 slot stays empty", 32'(r_hit), 0);
    endtask

    task automatic t_replace();
        flush_all();
        for (int i = 0; i < 9; i++) fill(8'd5, 20'(32'h200 + i), 3'(i));
        lookup(8'd5, 20'h200); chk("R12 oldest evicted", 32'(r_hit), 0);
        lookup(8'd5, 20'h201); chk("R12 second kept", 32'(r_hit), 1);
        lookup(8'd5, 20'h208); chk("R12 newest present", 32'(r_hit), 1);
        chk("R12 newest perm", 32'(r_perm), 0);
    endtask

    task automatic t_global_only();
        flush_all();
        fill(8'd1, 20'h10, 3'd1);
        fill(8'd2, 20'h10, 3'd2);
        inval(3'd3, 1'b1, 1'b1, 1'b0, 20'h999, 8'd1);
        lookup(8'd1, 20'h10);
        chk("R13 scoped variant keeps d1", 32'(r_hit), 1);
        chk("R13 global variant drops d1", 32'(r_ghit), 0);
        lookup(8'd2, 20'h10);
        chk("R13 global variant drops d2", 32'(r_ghit), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_lookup();
        t_refill();
        t_other_op();
        t_global();
        t_domain();
        t_page_all();
        t_page_dom();
        t_napot();
        t_all_ones();
        t_same_cycle();
        t_replace();
        t_global_only();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule